// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block is the coherence engine of one core's small direct-mapped, write-back cache. Several of these controllers share one atomic snooping bus. Each line is in one of three states: invalid, shared or modified. Processor loads and stores are served locally whenever the line state allows it. Otherwise the controller requests the bus, waits for a grant from an external arbiter, and issues exactly one command per grant. A command is a read, a read-for-ownership, an upgrade that carries no data, or a write-back.

While it waits, the controller watches every command that other cores place on the bus. A modified copy answers a read by driving its data onto the snoop-response lines and dropping to shared. Any copy that sees an ownership command for its line becomes invalid, so a write never updates a remote copy. The processor interface holds the processor stalled from miss detection until the bus transaction finishes, which makes each transaction atomic. A request stays asserted with its operands stable until `cpu_done` pulses.

Top module: `snoop_cache_ctl`

## Requirements
- R1: After reset every line is invalid and `cpu_done` and `bus_req` are low. Bus command code 0 means idle, and the first access to any address misses.
- R2: A load to a line that is not held issues exactly one bus command of code 1 (read) for that address, returns the fetched word and leaves the line shared. A repeated load to the same line completes in 1 cycle with no bus command.
- R3: A store to a line that is not held issues exactly one command of code 2 (read-for-ownership) for that address, and the line becomes modified with the store data.
- R4: A store to a shared line issues exactly one command of code 3 (upgrade, no data). Every other cached copy of that line becomes invalid, and an upgrade is never issued unless the line is held shared.
- R5: A store to a modified line completes 1 cycle after the request with no bus command.
- R6: A snooped read that hits a modified line asserts `snp_dirty` with the line's data, so the responder returns it and writes it to memory. The line drops to shared, so a later local store must upgrade.
- R7: A snooped read-for-ownership or upgrade that hits a line makes it invalid, so the next local access misses. A modified copy also supplies its data.
- R8: A miss whose line slot (index = address bits 1:0 with the default parameters) holds a different, modified line first issues code 4 (write-back) with the victim's address and data. Only after that does it issue the fetch.
- R9: A bus command is only issued in a granted cycle, and `bus_req` stays high until granted. `cpu_done` pulses only after the final grant, so an uncontended miss takes 2 cycles and one with a write-back takes 3.
- R10: When two cores upgrade the same shared line in the same cycle, the arbitration winner upgrades first. The loser is invalidated while waiting and then issues a read-for-ownership, so its value is the final one.
- R11: If a snooped command targets the slot of a pending processor request in the same cycle, the snoop is applied first and the processor access is decided one cycle later on the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant for the current cycle |
| bus_cmd | output | 3 | Command driven in a granted cycle (0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back) |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data returned in the granted cycle |
| snp_cmd | input | 3 | Command of another core seen on the bus |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_dirty | output | 1 | This cache owns the snooped line and supplies it |
| snp_data | output | DATA_W | Supplied line data |

## Verification
Several rules are checked by assertions in every cycle. Commands appear only under grant, and a request is held until granted. An upgrade is never issued for a line not held shared, a fetch never leaves a dirty victim behind, and no upgrade reaches a cache that owns the line. A data supply happens only for read-type snoops, and a snoop and a fill never write the same slot at once. Other behaviour appears only in the bench's two-core scenarios with a round-robin arbiter and a flat memory. These cover the returned data after ownership moves, the exact command sequence and latency of each access, the loser of a racing upgrade falling back to read-for-ownership, and the one-cycle deferral when a snoop collides with a pending store.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_MOD = 2'd2} line_st_e;
  typedef enum logic [2:0] {BC_NONE = 3'd0, BC_RD = 3'd1, BC_RDX = 3'd2,
                            BC_UPG = 3'd3, BC_WB = 3'd4} bus_cmd_e;
  typedef enum logic [1:0] {FS_IDLE, FS_WB, FS_BUS, FS_DONE} fsm_e;
endpackage

// File: rtl/snoop_line_store.sv
module snoop_line_store
  import snoop_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic              c_we,
  input  line_st_e          c_st,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic [DATA_W-1:0] c_data,
  output line_st_e          c_st_o,
  output logic [TAG_W-1:0]  c_tag_o,
  output logic [DATA_W-1:0] c_data_o,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_we,
  input  line_st_e          s_st,
  output line_st_e          s_st_o,
  output logic [TAG_W-1:0]  s_tag_o,
  output logic [DATA_W-1:0] s_data_o
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_a  [LINES];
  logic [TAG_W-1:0]  tag_a [LINES];
  logic [DATA_W-1:0] dat_a [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              snp_sel, cpu_sel, fill_en;

    always_comb begin
      snp_sel = s_we && (s_idx == IDX_W'(i));
      cpu_sel = c_we && (c_idx == IDX_W'(i));
      fill_en = cpu_sel && !snp_sel;
      st_d    = st_q;
      if (snp_sel)      st_d = s_st;
      else if (cpu_sel) st_d = c_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LN_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (fill_en) begin
        tag_q <= c_tag;
        dat_q <= c_data;
      end
    end

    assign st_a[i]  = st_q;
    assign tag_a[i] = tag_q;
    assign dat_a[i] = dat_q;
  end

  assign c_st_o   = st_a[c_idx];
  assign c_tag_o  = tag_a[c_idx];
  assign c_data_o = dat_a[c_idx];
  assign s_st_o   = st_a[s_idx];
  assign s_tag_o  = tag_a[s_idx];
  assign s_data_o = dat_a[s_idx];

  // R11: the controller never lets a fill and a snoop update the same slot together
  assert_port_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_we && c_we && (s_idx == c_idx)));
endmodule

// File: rtl/snoop_resp.sv
module snoop_resp
  import snoop_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  bus_cmd_e          s_cmd,
  input  logic [TAG_W-1:0]  s_tag,
  input  line_st_e          l_st,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_dat,
  output logic              st_we,
  output line_st_e          st_new,
  output logic              dirty,
  output logic [DATA_W-1:0] data
);
  logic hit;

  always_comb begin
    hit    = (l_st != LN_INV) && (l_tag == s_tag);
    st_we  = 1'b0;
    st_new = l_st;
    dirty  = 1'b0;
    case (s_cmd)
      BC_RD: if (hit && l_st == LN_MOD) begin
        st_we  = 1'b1;
        st_new = LN_SHR;
        dirty  = 1'b1;
      end
      BC_RDX: if (hit) begin
        st_we  = 1'b1;
        st_new = LN_INV;
        dirty  = (l_st == LN_MOD);
      end
      BC_UPG: if (hit) begin
        st_we  = 1'b1;
        st_new = LN_INV;
      end
      default: ;
    endcase
    data = dirty ? l_dat : '0;
  end
endmodule

// File: rtl/snoop_cache_ctl.sv
module snoop_cache_ctl
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_e              st_q, nxt;
  logic [DATA_W-1:0] rdata_q, rd_d;
  logic              rd_en, fill_bus;
  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;
  line_st_e          l_st, c_st, sl_st, s_new;
  logic [TAG_W-1:0]  l_tag, sl_tag;
  logic [DATA_W-1:0] l_dat, sl_dat, c_dat, c_dat_w;
  logic              c_we, s_we;
  logic              tag_hit, victim_dirty, clash;
  bus_cmd_e          cmd_d, snp_c;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign snp_c = bus_cmd_e'(snp_cmd);

  snoop_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .c_idx(c_idx), .c_we(c_we), .c_st(c_st), .c_tag(c_tag), .c_data(c_dat_w),
    .c_st_o(l_st), .c_tag_o(l_tag), .c_data_o(l_dat),
    .s_idx(s_idx), .s_we(s_we), .s_st(s_new),
    .s_st_o(sl_st), .s_tag_o(sl_tag), .s_data_o(sl_dat)
  );

  snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_resp (
    .s_cmd(snp_c), .s_tag(s_tag), .l_st(sl_st), .l_tag(sl_tag), .l_dat(sl_dat),
    .st_we(s_we), .st_new(s_new), .dirty(snp_dirty), .data(snp_data)
  );

  assign tag_hit      = (l_st != LN_INV) && (l_tag == c_tag);
  assign victim_dirty = (l_st == LN_MOD) && (l_tag != c_tag);
  assign clash        = (snp_c != BC_NONE) && (s_idx == c_idx);

  // Next-state and bus command decode
  always_comb begin
    nxt       = st_q;
    c_we      = 1'b0;
    c_st      = l_st;
    c_dat     = l_dat;
    fill_bus  = 1'b0;
    rd_en     = 1'b0;
    bus_req   = 1'b0;
    cmd_d     = BC_NONE;
    bus_addr  = cpu_addr;
    bus_wdata = '0;
    case (st_q)
      FS_IDLE: if (cpu_req && !clash) begin
        if (!cpu_we && tag_hit) begin
          rd_en = 1'b1;
          nxt   = FS_DONE;
        end else if (cpu_we && tag_hit && l_st == LN_MOD) begin
          c_we  = 1'b1;
          c_st  = LN_MOD;
          c_dat = cpu_wdata;
          nxt   = FS_DONE;
        end else if (victim_dirty) begin
          nxt = FS_WB;
        end else begin
          nxt = FS_BUS;
        end
      end
      FS_WB: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          nxt = FS_BUS;
          if (victim_dirty) begin
            cmd_d     = BC_WB;
            bus_addr  = {l_tag, c_idx};
            bus_wdata = l_dat;
            c_we      = 1'b1;
            c_st      = LN_INV;
          end
        end
      end
      FS_BUS: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          nxt  = FS_DONE;
          c_we = 1'b1;
          if (cpu_we) begin
            cmd_d = (tag_hit && l_st == LN_SHR) ? BC_UPG : BC_RDX;
            c_st  = LN_MOD;
            c_dat = cpu_wdata;
          end else begin
            cmd_d    = BC_RD;
            c_st     = LN_SHR;
            fill_bus = 1'b1;
            rd_en    = 1'b1;
          end
        end
      end
      default: nxt = FS_IDLE;
    endcase
  end

  assign c_dat_w = fill_bus ? bus_rdata : c_dat;
  assign rd_d    = fill_bus ? bus_rdata : l_dat;
  assign bus_cmd = cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= rd_d;
  end

  assign cpu_done  = (st_q == FS_DONE);
  assign cpu_rdata = rdata_q;

  // R9: commands only under grant; request held until granted; no done while requesting
  assert_cmd_gnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d != BC_NONE) |-> bus_gnt);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req);
  // R8: a fetch never leaves a dirty victim in the slot
  assert_wb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d == BC_RD || cmd_d == BC_RDX) |-> !victim_dirty);
  // R4: upgrade only for a shared copy of the stored line
  assert_upg_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_d == BC_UPG) |-> (cpu_we && tag_hit && l_st == LN_SHR));
  // R4: another core never upgrades a line this cache owns
  assert_upg_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_c == BC_UPG) |-> !(sl_st == LN_MOD && sl_tag == s_tag));
  // R5: a store hit on a modified line finishes next cycle without the bus
  assert_hit_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_IDLE && cpu_req && cpu_we && tag_hit && l_st == LN_MOD && !clash)
      |=> (cpu_done && !bus_req));
  // R6: data is supplied only for read-type snoops
  assert_supply_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> (snp_c == BC_RD || snp_c == BC_RDX));
endmodule

// File: tb/sim_snoop_cache_ctl.sv
`timescale 1ns/1ps
module sim_snoop_cache_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req, we, done, breq, gnt, sdirty;
  logic [7:0]  addr [2];
  logic [7:0]  baddr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic [31:0] bwd [2];
  logic [31:0] sdata [2];
  logic [2:0]  bcmd [2];
  logic [2:0]  scmd [2];
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wd, bus_rd;
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  logic        last = 1'b0;
  int          checks = 0, errors = 0, cyc = 0;
  int          log_q[$];
  logic [32:0] exp0[$];
  logic [32:0] exp1[$];

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < 2; i++) begin : g_core
    snoop_cache_ctl #(.ADDR_W(8), .DATA_W(32), .IDX_W(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(req[i]), .cpu_we(we[i]), .cpu_addr(addr[i]), .cpu_wdata(wdata[i]),
      .cpu_done(done[i]), .cpu_rdata(rdata[i]),
      .bus_req(breq[i]), .bus_gnt(gnt[i]), .bus_cmd(bcmd[i]), .bus_addr(baddr[i]),
      .bus_wdata(bwd[i]), .bus_rdata(bus_rd),
      .snp_cmd(scmd[i]), .snp_addr(bus_addr), .snp_dirty(sdirty[i]), .snp_data(sdata[i])
    );
  end

  // round-robin arbiter
  assign gnt[0] = breq[0] && (!breq[1] || last);
  assign gnt[1] = breq[1] && (!breq[0] || !last);
  always @(posedge clk) if (|gnt) last <= gnt[1];

  always_comb begin
    bus_cmd = 3'd0; bus_addr = 8'd0; bus_wd = 32'd0;
    if (gnt[0])      begin bus_cmd = bcmd[0]; bus_addr = baddr[0]; bus_wd = bwd[0]; end
    else if (gnt[1]) begin bus_cmd = bcmd[1]; bus_addr = baddr[1]; bus_wd = bwd[1]; end
  end
  assign scmd[0] = gnt[0] ? 3'd0 : bus_cmd;
  assign scmd[1] = gnt[1] ? 3'd0 : bus_cmd;
  assign bus_rd  = sdirty[0] ? sdata[0] : (sdirty[1] ? sdata[1] : mem[bus_addr]);

  // flat memory responder
  always @(posedge clk) begin
    if (bus_cmd == 3'd4) mem[bus_addr] <= bus_wd;
    else if (bus_cmd == 3'd1 && (|sdirty)) mem[bus_addr] <= bus_rd;
  end

  function automatic int ent(int c, int cmd, int a);
    return (c << 16) | (cmd << 8) | a;
  endfunction

  always @(negedge clk) if (bus_cmd != 3'd0) log_q.push_back(ent(gnt[1], bus_cmd, bus_addr));

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // scoreboard monitor: every completion pops one expected item
  task automatic pop_cmp(int c);
    logic [32:0] e;
    if ((c == 0 && exp0.size() == 0) || (c == 1 && exp1.size() == 0)) begin
      chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
      return;
    end
    e = (c == 0) ? exp0.pop_front() : exp1.pop_front();
    if (e[32]) chk(rdata[c] == e[31:0], "R2 load data", rdata[c], e[31:0]);
  endtask

  always @(negedge clk) begin
    if (rst_n && done[0]) pop_cmp(0);
    if (rst_n && done[1]) pop_cmp(1);
  end

  task automatic op(int c, bit w, logic [7:0] a, logic [31:0] d, output int lat);
    if (c == 0) exp0.push_back({!w, w ? 32'd0 : ref_mem[a]});
    else        exp1.push_back({!w, w ? 32'd0 : ref_mem[a]});
    addr[c] = a; we[c] = w; wdata[c] = d; req[c] = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done[c]);
    req[c] = 1'b0;
    if (w) ref_mem[a] = d;
    @(negedge clk);
  endtask

  task automatic chk_log(string r, int n, int e0, int e1);
    chk(log_q.size() == n, r, log_q.size(), n);
    if (n > 0 && log_q.size() > 0) chk(log_q[0] == e0, r, log_q[0], e0);
    if (n > 1 && log_q.size() > 1) chk(log_q[1] == e1, r, log_q[1], e1);
    log_q.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=%0d expected<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int l0, l1;
    for (int k = 0; k < 256; k++) begin mem[k] = 32'h1000 + k; ref_mem[k] = 32'h1000 + k; end
    req = '0; we = '0;
    for (int k = 0; k < 2; k++) begin addr[k] = '0; wdata[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 2'b00, "R1 done after reset", done, 0);
    chk(breq == 2'b00, "R1 bus_req after reset", breq, 0);
    log_q.delete();

    // R1/R2 first load misses with a read (code 1), 2-cycle latency (R9)
    op(0, 0, 8'h10, 0, l0);
    chk_log("R2 read miss command", 1, ent(0, 1, 8'h10), 0);
    chk(l0 == 2, "R9 miss latency", l0, 2);
    op(0, 0, 8'h10, 0, l0);
    chk_log("R2 load hit silent", 0, 0, 0);
    chk(l0 == 1, "R2 hit latency", l0, 1);
    op(1, 0, 8'h10, 0, l1);
    chk_log("R2 second core read", 1, ent(1, 1, 8'h10), 0);

    // R4 store to shared line upgrades (code 3)
    op(0, 1, 8'h10, 32'hAAAA, l0);
    chk_log("R4 upgrade", 1, ent(0, 3, 8'h10), 0);
    // R4/R6 invalidated reader misses, owner supplies and memory is refreshed
    op(1, 0, 8'h10, 0, l1);
    chk_log("R4 invalidated copy misses", 1, ent(1, 1, 8'h10), 0);
    chk(mem[8'h10] == 32'hAAAA, "R6 memory refreshed by supply", mem[8'h10], 32'hAAAA);
    op(0, 1, 8'h10, 32'hBBBB, l0);
    chk_log("R6 owner dropped to shared", 1, ent(0, 3, 8'h10), 0);
    // R5 store hit on modified
    op(0, 1, 8'h10, 32'hCCCC, l0);
    chk_log("R5 no bus on modified store", 0, 0, 0);
    chk(l0 == 1, "R5 store hit latency", l0, 1);
    // R3 store miss uses read-for-ownership (code 2), R7 owner invalidated
    op(1, 1, 8'h10, 32'hDDDD, l1);
    chk_log("R3 read-for-ownership", 1, ent(1, 2, 8'h10), 0);
    op(0, 0, 8'h10, 0, l0);
    chk_log("R7 old owner misses", 1, ent(0, 1, 8'h10), 0);
    chk(mem[8'h10] == 32'hDDDD, "R7 supplied data reached memory", mem[8'h10], 32'hDDDD);

    // R8 eviction of a modified victim (index = addr[1:0])
    op(0, 1, 8'h14, 32'h1414, l0);
    chk_log("R3 clean victim no write-back", 1, ent(0, 2, 8'h14), 0);
    op(0, 1, 8'h18, 32'h1818, l0);
    chk_log("R8 write-back before fetch", 2, ent(0, 4, 8'h14), ent(0, 2, 8'h18));
    chk(l0 == 3, "R9 latency with write-back", l0, 3);
    chk(mem[8'h14] == 32'h1414, "R8 victim data in memory", mem[8'h14], 32'h1414);
    op(0, 0, 8'h14, 0, l0);
    chk_log("R8 load evicts modified", 2, ent(0, 4, 8'h18), ent(0, 1, 8'h14));

    // R11 snoop collides with pending store to same slot
    op(0, 1, 8'h25, 32'h2525, l0);
    log_q.delete();
    fork
      begin op(1, 0, 8'h25, 0, l1); end
      begin @(negedge clk); op(0, 1, 8'h25, 32'h5555, l0); end
    join
    chk_log("R11 snoop first then upgrade", 2, ent(1, 1, 8'h25), ent(0, 3, 8'h25));
    chk(l1 == 2, "R11 reader latency", l1, 2);
    chk(l0 == 3, "R11 deferred store latency", l0, 3);
    op(1, 0, 8'h25, 0, l1);

    // R10 racing upgrades
    op(0, 0, 8'h32, 0, l0);
    op(1, 0, 8'h32, 0, l1);
    log_q.delete();
    fork
      begin op(0, 1, 8'h32, 32'hA0A0, l0); end
      begin op(1, 1, 8'h32, 32'hB0B0, l1); end
    join
    chk(log_q.size() == 2, "R10 two commands", log_q.size(), 2);
    if (log_q.size() == 2) begin
      chk(((log_q[0] >> 8) & 7) == 3, "R10 winner upgrades", (log_q[0] >> 8) & 7, 3);
      chk(((log_q[1] >> 8) & 7) == 2, "R10 loser read-for-ownership", (log_q[1] >> 8) & 7, 2);
      chk((log_q[0] >> 16) != (log_q[1] >> 16), "R10 distinct cores", log_q[1] >> 16, 32'(!(log_q[0] >> 16)));
    end
    log_q.delete();
    op(0, 0, 8'h32, 0, l0);
    op(1, 0, 8'h32, 0, l1);

    repeat (2) @(negedge clk);
    chk(exp0.size() == 0 && exp1.size() == 0, "R9 all completions seen",
        exp0.size() + exp1.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule